// File: doc/BRIEF.md
# LED Flasher with Interrupt Event Counter

This block drives a byte-wide LED port. While idle it is in flash mode: once per one-second interval the port switches between all-zeros and all-ones, starting from all-zeros after reset. The length of one second is set at run time by the `ticks_per_sec` input, which gives the number of clock cycles in one interval.

A rising edge on the interrupt request input is accepted when the block is in flash mode. On an accepted edge, an internal 8-bit event count goes up by one and the new count appears on the LEDs. The count stays on the port for four one-second intervals. Flash mode then resumes from the pattern that was showing when the interrupt arrived. Request edges that arrive while a count is on display are dropped and are not counted. The request line needs no debouncing; it is taken to be clean.

Top module: `led_irq_display`

## Requirements
- R1: While reset is asserted, and just after it is released, `led` is 8'h00 and `show_count` is 0. The event count also starts at 0, so the first accepted event shows 8'h01.
- R2: In flash mode, `led` changes to its bitwise complement every `ticks_per_sec` clock cycles. Seen from the port, it alternates between 8'h00 and 8'hFF. The first change comes `ticks_per_sec` cycles after reset is released.
- R3: A rising edge on `irq_req` in flash mode is accepted. The edge is sampled at a clock edge, and on that same clock edge `show_count` goes to 1 and `led` shows the incremented event count.
- R4: While `show_count` is 1, `led` holds the count. The display lasts exactly 4 × `ticks_per_sec` cycles after the accepting edge, and then `show_count` returns to 0.
- R5: Rising edges on `irq_req` while `show_count` is 1 are ignored. They do not change the count, so the next accepted event shows the old count plus one, and they do not lengthen the display.
- R6: When the display ends, `led` returns to the flash pattern that was on the port just before the accepted event. The next complement follows one full interval later.
- R7: `irq_req` is edge-detected. A request that stays high through and past a display window is counted only once.
- R8: The event count wraps. The accepted event after a count of 8'hFF shows 8'h00.
- R9: A `ticks_per_sec` value of 0 or 1 makes each interval one clock cycle long, so in flash mode `led` complements on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt request; its rising edges are the events |
| ticks_per_sec | input | DIV_W (16) | Number of clock cycles in one interval |
| led | output | LED_W (8) | LED pattern or event count |
| show_count | output | 1 | 1 while the event count is on display |

## Verification
The hardest states to reach are the ones where the request line does something while a count is on display. One case is a second rising edge that lands in the middle of the display. The other is a request held high across the moment the display ends, where a careless design would either lengthen the window or count the held level a second time when flash mode resumes. The stimulus reaches both by sequencing `irq_req` against the cycle count since reset: it pulses the line inside a running window, and it keeps the line high from the accepting edge until after the window has closed. It then reads the next accepted count on the port to show that nothing was counted in between. The count wrap is reached by shortening the interval to one cycle and running back-to-back events past 255.

// File: rtl/lid_pkg.sv
`timescale 1ns/1ps
package lid_pkg;

  // Output mode of the LED port.
  typedef enum logic {
    MODE_FLASH = 1'b0,
    MODE_SHOW  = 1'b1
  } lid_mode_e;

  // Default number of one-second intervals the count stays on display.
  localparam int unsigned LID_WIN_SECS_DEF = 4;

endpackage

// File: rtl/lid_prescaler.sv
`timescale 1ns/1ps
module lid_prescaler #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] ticks,
  output logic             sec_pulse
);

  // Terminal count for one interval: 0 or 1 cycles per second both mean
  // a pulse on every cycle.
  function automatic logic [DIV_W-1:0] last_tick(input logic [DIV_W-1:0] t);
    if (t <= DIV_W'(1)) return '0;
    return t - DIV_W'(1);
  endfunction

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] tc;

  assign tc = last_tick(ticks);

  // Greater-or-equal so that lowering ticks on the fly cannot strand the
  // counter above the new terminal value.
  assign sec_pulse = (cnt_q >= tc);

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (restart || sec_pulse) cnt_q <= '0;
    else                           cnt_q <= cnt_q + DIV_W'(1);
  end

  // R2: with an interval longer than one cycle and the divider held
  // steady, two pulses never come on back-to-back cycles.
  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && last_tick(ticks) != '0) |=> (!$stable(ticks) || !sec_pulse));

endmodule

// File: rtl/lid_irq_edge.sv
`timescale 1ns/1ps
module lid_irq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  output logic irq_rise
);

  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_req;
  end

  assign irq_rise = irq_req & ~irq_q;

  // R7: a request held high yields one event, not one per cycle.
  a_r7_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rise |=> !irq_rise);

endmodule

// File: rtl/lid_window.sv
`timescale 1ns/1ps
module lid_window #(
  parameter int unsigned SECS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sec_pulse,
  output logic active,
  output logic expire
);

  localparam int unsigned SW = (SECS > 1) ? $clog2(SECS) : 1;

  function automatic logic last_sec(input logic [SW-1:0] n);
    return n == SW'(SECS - 1);
  endfunction

  logic [SW-1:0] sec_n_q;
  logic          active_q;

  assign active = active_q;
  assign expire = active_q & sec_pulse & last_sec(sec_n_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sec_n_q  <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      sec_n_q  <= '0;
    end else if (expire) begin
      active_q <= 1'b0;
      sec_n_q  <= '0;
    end else if (active_q && sec_pulse) begin
      sec_n_q  <= sec_n_q + SW'(1);
    end
  end

  // R4: the window closes on the cycle after its final second pulse.
  a_r4_close_after_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !start) |=> !active);

endmodule

// File: rtl/led_irq_display.sv
`timescale 1ns/1ps
module led_irq_display #(
  parameter int unsigned LED_W    = 8,
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned WIN_SECS = lid_pkg::LID_WIN_SECS_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_req,
  input  logic [DIV_W-1:0] ticks_per_sec,
  output logic [LED_W-1:0] led,
  output logic             show_count
);
  import lid_pkg::*;

  // Event counter step; wraps at the top of its range.
  function automatic logic [LED_W-1:0] bump(input logic [LED_W-1:0] c);
    return c + LED_W'(1);
  endfunction

  // Named internal events
  logic irq_rise;
  logic sec_pulse;
  logic win_active;
  logic expire;
  logic accept;
  logic toggle;
  lid_mode_e mode;

  logic [LED_W-1:0] count_q;
  logic [LED_W-1:0] flash_pat_q;
  logic [LED_W-1:0] led_q;

  lid_irq_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .irq_rise (irq_rise)
  );

  lid_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (accept),
    .ticks     (ticks_per_sec),
    .sec_pulse (sec_pulse)
  );

  lid_window #(.SECS(WIN_SECS)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .sec_pulse (sec_pulse),
    .active    (win_active),
    .expire    (expire)
  );

  assign mode   = win_active ? MODE_SHOW : MODE_FLASH;
  assign accept = irq_rise & (mode == MODE_FLASH);
  assign toggle = sec_pulse & (mode == MODE_FLASH) & ~accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q     <= '0;
      flash_pat_q <= '0;
      led_q       <= '0;
    end else begin
      if (accept) begin
        count_q <= bump(count_q);
        led_q   <= bump(count_q);
      end else if (expire) begin
        led_q   <= flash_pat_q;
      end else if (toggle) begin
        flash_pat_q <= ~flash_pat_q;
        led_q       <= ~flash_pat_q;
      end
    end
  end

  assign led        = led_q;
  assign show_count = (mode == MODE_SHOW);

  // R3: an accepted edge puts the next count on the port at once.
  a_r3_show_next_count: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (show_count && led == LED_W'($past(count_q) + 1'b1)));

  // R5: an edge during the display leaves the count untouched.
  a_r5_ignore_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rise && show_count) |=> (count_q == $past(count_q)));

  // R2: a flash step yields the complement of the previous port value.
  a_r2_flash_complement: assert property (@(posedge clk) disable iff (!rst_n)
    toggle |=> (led == ~$past(led)));

  // R6: on window end the saved flash pattern returns.
  a_r6_resume_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (led == $past(flash_pat_q) && !show_count));

  // R4: the display only ends on an interval boundary.
  a_r4_end_on_second: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(show_count) |-> $past(sec_pulse));

  // R8: the count after the top value is zero.
  a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && count_q == '1) |=> (led == '0));

endmodule

// File: tb/led_irq_display_tb.sv
`timescale 1ns/1ps
module led_irq_display_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic [15:0] ticks = 16'd4;
  logic [7:0]  led;
  logic        show;

  always #10 clk = ~clk;   // 50 MHz

  led_irq_display u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_req       (irq),
    .ticks_per_sec (ticks),
    .led           (led),
    .show_count    (show)
  );

  // Clock edges since reset release.
  int cyc = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  typedef struct {
    int         at;
    logic [7:0] led;
    logic       show;
    string      req;
  } exp_t;

  exp_t sb[$];
  int   tests = 0;
  int   fails = 0;
  bit   done  = 0;

  task automatic expect_at(int at, logic [7:0] l, logic s, string req);
    exp_t e;
    e.at = at; e.led = l; e.show = s; e.req = req;
    sb.push_back(e);
  endtask

  task automatic check(bit ok, string req, string what);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  // Monitor: compare queued expectations against the ports.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      tests++;
      if (e.at != cyc || led !== e.led || show !== e.show) begin
        fails++;
        $display("FAIL %s at cycle %0d: led=%h show=%b expected led=%h show=%b (due %0d)",
                 e.req, cyc, led, show, e.led, e.show, e.at);
      end
    end
  end

  task automatic wait_until(int target);
    while (cyc < target) @(negedge clk);
  endtask

  initial begin
    int t;
    int c;
    int evc;
    logic [7:0] pat;
    logic [7:0] a;
    t = 4;
    evc = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(led === 8'h00 && show === 1'b0, "R1",
          $sformatf("in reset led=%h show=%b expected 00/0", led, show));

    // R2: flash cadence after reset release (R1 right after release)
    expect_at(1,       8'h00, 1'b0, "R1");
    expect_at(t - 1,   8'h00, 1'b0, "R2");
    expect_at(t,       8'hFF, 1'b0, "R2");
    expect_at(2*t - 1, 8'hFF, 1'b0, "R2");
    expect_at(2*t,     8'h00, 1'b0, "R2");
    expect_at(3*t,     8'hFF, 1'b0, "R2");
    rst_n = 1'b1;
    wait_until(3*t + 2);

    // Event 1: R3, R4, R6; request held high across window end (R7)
    c = cyc; pat = led; irq = 1'b1; evc++;
    check(pat === 8'h00 || pat === 8'hFF, "R2",
          $sformatf("flash pattern %h expected 00 or FF", pat));
    expect_at(c + 1,       8'(evc), 1'b1, "R3");
    expect_at(c + 4*t,     8'(evc), 1'b1, "R4");
    expect_at(c + 1 + 4*t, pat,     1'b0, "R4");
    expect_at(c + 5*t,     pat,     1'b0, "R6");
    expect_at(c + 1 + 5*t, ~pat,    1'b0, "R6");
    expect_at(c + 2 + 5*t, ~pat,    1'b0, "R7");
    wait_until(c + 2 + 5*t);
    irq = 1'b0;
    wait_until(c + 4 + 5*t);

    // Event 2: a second edge inside the window is ignored (R5)
    c = cyc; pat = led; irq = 1'b1; evc++;
    expect_at(c + 1, 8'(evc), 1'b1, "R3");
    @(negedge clk); irq = 1'b0;
    @(negedge clk); irq = 1'b1;   // rise while displaying
    @(negedge clk); irq = 1'b0;
    expect_at(c + 2*t,     8'(evc), 1'b1, "R5");
    expect_at(c + 1 + 4*t, pat,     1'b0, "R5");
    wait_until(c + 3 + 4*t);

    // Event 3: shows old count plus one, nothing counted in between (R5, R7)
    c = cyc; irq = 1'b1; evc++;
    expect_at(c + 1, 8'(evc), 1'b1, "R5");
    @(negedge clk); irq = 1'b0;
    wait_until(c + 3 + 4*t);

    // R9: one-cycle interval for ticks of 1 and of 0
    ticks = 16'd1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      a = led;
      @(negedge clk);
      check(led === ~a && show === 1'b0, "R9",
            $sformatf("ticks=1 led=%h expected %h", led, ~a));
    end
    ticks = 16'd0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      a = led;
      @(negedge clk);
      check(led === ~a && show === 1'b0, "R9",
            $sformatf("ticks=0 led=%h expected %h", led, ~a));
    end

    // R8: run events up to the wrap with one-cycle intervals
    ticks = 16'd1;
    @(negedge clk);
    for (int k = evc + 1; k <= 256; k++) begin
      c = cyc; irq = 1'b1;
      if (k >= 255) expect_at(c + 1, 8'(k), 1'b1, "R8");
      @(negedge clk); irq = 1'b0;
      repeat (5) @(negedge clk);
    end

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R4",
          $sformatf("%0d expectations left unmatched, expected 0", sb.size()));
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // Watchdog
  initial begin
    #(20 * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule